// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It keeps a shift register of recent branch directions and a table of 2-bit saturating counters. The counter used for a branch is selected by XORing the fetch address bits above the halfword alignment with the history. The guess is the upper bit of that counter. The guess is shifted into the history at once, so a run of branches back to back is looked up under different histories.

Each prediction returns a tag that holds the table index and the history as it was before the shift. When the branch resolves, a later stage hands the tag back with the real direction and a flag saying whether the guess was wrong. The counter at the tagged index is trained. On a wrong guess, the history is rebuilt from the tagged history with the real direction appended.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is all zeros, so every lookup predicts not taken and carries a zero history field in its tag.
- R2: The lookup index is `fetch_pc_idx XOR history`. `fetch_pc_idx` holds address bits [HIST_W:1]. `pred_tag` is `{index, history}`, with the index in the upper HIST_W bits and the history before the update in the lower HIST_W bits.
- R3: `pred_taken` is the most significant bit of the counter at the lookup index, read combinationally in the same cycle.
- R4: When `fetch_valid` is high and no recovery is taking place, the history shifts left by one at the clock edge, and `pred_taken` enters at bit 0.
- R5: When `fetch_valid` is low and no recovery is taking place, the history keeps its value, whatever `fetch_pc_idx` is.
- R6: On `res_valid`, the counter at the index field of `res_tag` moves one step toward 11 if `res_taken` is high, and one step toward 00 otherwise. It saturates at 11 and at 00.
- R7: Training uses only the index carried in `res_tag`, never an index formed from the current history.
- R8: On `res_valid` with `res_mispredict` high, the next history is the history field of `res_tag` shifted left by one, with `res_taken` entering at bit 0.
- R9: When a recovery and a valid fetch happen in the same cycle, the recovery value is the one that takes effect in the history.
- R10: When a lookup and a training write hit the same counter in one cycle, the lookup returns the old value. The new value is visible from the next cycle.
- R11: A resolution with `res_mispredict` low leaves the history unchanged when there is no valid fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A branch is being predicted this cycle and may shift the history |
| fetch_pc_idx | input | HIST_W | Fetch address bits [HIST_W:1] |
| pred_taken | output | 1 | Predicted direction |
| pred_tag | output | 2*HIST_W | Checkpoint {index, pre-update history} |
| res_valid | input | 1 | A resolved branch is presented |
| res_tag | input | 2*HIST_W | Tag that was returned with that branch's prediction |
| res_taken | input | 1 | Actual direction |
| res_mispredict | input | 1 | The prediction for this branch was wrong |

## Verification
The bench builds the block with HIST_W = 4, which gives a 16-entry table. A few resolutions are then enough to drive a counter into both saturation limits. A handful of taken predictions moves the history through values in which the index from the stored tag differs from the index the current history would give. A reference model of the table and the history, written from the requirements, is checked against every lookup. Directed cases cover recovery priority, same-entry read during a write, and history hold while fetch is stalled.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b01;

    // saturating step toward the resolved direction
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t n;
        if (taken) n = (c == 2'b11) ? c : c + 2'b01;
        else       n = (c == 2'b00) ? c : c - 2'b01;
        return n;
    endfunction

    function automatic logic ctr_dir(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
    parameter int HIST_W = 10
) (
    input  logic [HIST_W-1:0] pc_bits,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] idx
);
    always_comb idx = pc_bits ^ hist;
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] rd_idx,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);
    localparam int DEPTH = 1 << HIST_W;

    ctr_t cnt_q [DEPTH];
    ctr_t wr_old;

    assign rd_ctr = cnt_q[rd_idx];
    assign wr_old = cnt_q[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_RESET;
        end else if (wr_en) begin
            cnt_q[wr_idx] <= ctr_step(wr_old, wr_taken);
        end
    end

    // R6: a taken resolution never lowers the counter
    p_train_up_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=> (cnt_q[$past(wr_idx)] >= $past(wr_old)));

    // R6: a not-taken resolution never raises the counter
    p_train_down_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken) |=> (cnt_q[$past(wr_idx)] <= $past(wr_old)));
endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              rec_en,
    input  logic [HIST_W-1:0] rec_hist,
    input  logic              rec_bit,
    output logic [HIST_W-1:0] hist_q
);
    always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (rec_en)   hist_q <= {rec_hist[HIST_W-2:0], rec_bit};
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !rec_en) |=> (hist_q == $past(hist_q)));

    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !rec_en) |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    p_recover_r8: assert property (@(posedge clk) disable iff (rst)
        rec_en |=> (hist_q[0] == $past(rec_bit)));

    p_priority_r9: assert property (@(posedge clk) disable iff (rst)
        (rec_en && shift_en) |=> (hist_q[HIST_W-1:1] == $past(rec_hist[HIST_W-2:0])));
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fetch_valid,
    input  logic [HIST_W-1:0]     fetch_pc_idx,
    output logic                  pred_taken,
    output logic [2*HIST_W-1:0]   pred_tag,
    input  logic                  res_valid,
    input  logic [2*HIST_W-1:0]   res_tag,
    input  logic                  res_taken,
    input  logic                  res_mispredict
);
    localparam int TAG_W = 2 * HIST_W;

    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] look_idx;
    logic [HIST_W-1:0] res_idx;
    logic [HIST_W-1:0] res_hist;
    ctr_t              look_ctr;
    logic              recover;

    assign res_idx  = res_tag[TAG_W-1:HIST_W];
    assign res_hist = res_tag[HIST_W-1:0];
    assign recover  = res_valid && res_mispredict;

    gshare_index #(.HIST_W(HIST_W)) u_index (
        .pc_bits (fetch_pc_idx),
        .hist    (hist),
        .idx     (look_idx)
    );

    gshare_pht #(.HIST_W(HIST_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_ctr   (look_ctr),
        .wr_en    (res_valid),
        .wr_idx   (res_idx),
        .wr_taken (res_taken)
    );

    gshare_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (fetch_valid),
        .shift_bit (pred_taken),
        .rec_en    (recover),
        .rec_hist  (res_hist),
        .rec_bit   (res_taken),
        .hist_q    (hist)
    );

    assign pred_taken = ctr_dir(look_ctr);
    assign pred_tag   = {look_idx, hist};

    // R11: a correct resolution with no fetch keeps the history
    p_no_recover_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_mispredict && !fetch_valid) |=> (pred_tag[HIST_W-1:0] == $past(pred_tag[HIST_W-1:0])));
endmodule

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_valid;
    logic [HW-1:0] fetch_pc_idx;
    logic          pred_taken;
    logic [2*HW-1:0] pred_tag;
    logic          res_valid;
    logic [2*HW-1:0] res_tag;
    logic          res_taken;
    logic          res_mispredict;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0]    m_pht [1 << HW];
    logic [HW-1:0] m_ghr;

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_predictor #(.HIST_W(HW)) uut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc_idx(fetch_pc_idx),
        .pred_taken(pred_taken), .pred_tag(pred_tag), .res_valid(res_valid),
        .res_tag(res_tag), .res_taken(res_taken), .res_mispredict(res_mispredict)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    // one cycle: drive, compare lookup with model, clock, update model
    task automatic step(input logic fv, input logic [HW-1:0] pc, input logic rv,
                        input logic [7:0] rt, input logic rtk, input logic rm,
                        input string req, output logic o_pred, output logic [7:0] o_tag);
        logic [HW-1:0] idx;
        logic exp_pred;
        @(negedge clk);
        fetch_valid = fv; fetch_pc_idx = pc;
        res_valid = rv; res_tag = rt; res_taken = rtk; res_mispredict = rm;
        #1;
        idx = pc ^ m_ghr;
        exp_pred = m_pht[idx][1];
        check(req, {7'd0, pred_taken}, {7'd0, exp_pred});
        check(req, pred_tag, {idx, m_ghr});
        o_pred = pred_taken; o_tag = pred_tag;
        @(posedge clk);
        if (rv) m_pht[rt[7:4]] = sat(m_pht[rt[7:4]], rtk);
        if (rv && rm)  m_ghr = {rt[2:0], rtk};
        else if (fv)   m_ghr = {m_ghr[2:0], exp_pred};
        #1;
        fetch_valid = 0; res_valid = 0; res_mispredict = 0;
    endtask

    task automatic peek(input logic [HW-1:0] idx, input string req, output logic p);
        logic [7:0] t;
        step(0, idx ^ m_ghr, 0, 8'h00, 0, 0, req, p, t);
    endtask

    task automatic train(input logic [HW-1:0] idx, input logic tk, input string req);
        logic p; logic [7:0] t;
        step(0, 4'h0, 1, {idx, 4'h0}, tk, 0, req, p, t);
    endtask

    task automatic t_reset;
        logic p; logic [7:0] t;
        step(0, 4'h5, 0, 8'h00, 0, 0, "R1", p, t);
        check("R1", {7'd0, p}, 8'd0);
        check("R1", {4'd0, t[3:0]}, 8'd0);
        check("R2", {4'd0, t[7:4]}, 8'h05);
    endtask

    task automatic t_saturate;
        logic p;
        for (int i = 0; i < 3; i++) train(4'h3, 1, "R6");
        peek(4'h3, "R6", p); check("R6", {7'd0, p}, 8'd1);
        train(4'h3, 0, "R6");
        peek(4'h3, "R6", p); check("R6", {7'd0, p}, 8'd1);  // 11 -> 10
        train(4'h3, 0, "R6");
        peek(4'h3, "R6", p); check("R6", {7'd0, p}, 8'd0);  // 10 -> 01
        for (int i = 0; i < 3; i++) train(4'h3, 0, "R6");
        train(4'h3, 1, "R6");
        peek(4'h3, "R6", p); check("R6", {7'd0, p}, 8'd0);  // 00 -> 01
        train(4'h3, 1, "R6");
        peek(4'h3, "R3", p); check("R3", {7'd0, p}, 8'd1);  // 01 -> 10
    endtask

    task automatic t_shift;
        logic p; logic [7:0] t;
        step(1, 4'h3, 0, 8'h00, 0, 0, "R4", p, t);
        check("R4", {7'd0, p}, 8'd1);
        step(1, 4'h2, 0, 8'h00, 0, 0, "R4", p, t);
        check("R4", {4'd0, t[3:0]}, 8'h01);
        step(1, 4'h0, 0, 8'h00, 0, 0, "R4", p, t);
        check("R4", {4'd0, t[3:0]}, 8'h03);
        step(1, 4'h0, 0, 8'h00, 0, 0, "R4", p, t);
        check("R4", {4'd0, t[3:0]}, 8'h07);
        check("R2", {4'd0, t[7:4]}, 8'h07);
    endtask

    task automatic t_stall;
        logic p; logic [7:0] t; logic [HW-1:0] g;
        g = m_ghr;
        step(0, 4'h3, 0, 8'h00, 0, 0, "R5", p, t);
        step(0, 4'hC, 0, 8'h00, 0, 0, "R5", p, t);
        step(0, 4'h9, 0, 8'h00, 0, 0, "R5", p, t);
        check("R5", {4'd0, t[3:0]}, {4'd0, g});
    endtask

    task automatic t_tag_train;
        logic p; logic [7:0] told, t; logic [HW-1:0] i, cur;
        step(1, 4'h6, 0, 8'h00, 0, 0, "R7", p, told);
        i = told[7:4];
        step(1, 4'h6, 0, 8'h00, 0, 0, "R7", p, t);
        step(0, 4'h0, 1, told, 1, 0, "R7", p, t);
        step(0, 4'h0, 1, told, 1, 0, "R7", p, t);
        peek(i, "R7", p);
        check("R7", {7'd0, p}, 8'd1);
        cur = 4'h6 ^ m_ghr;
        if (cur != i) begin
            peek(cur, "R7", p);
            check("R7", {7'd0, p}, {7'd0, m_pht[cur][1]});
        end
    endtask

    task automatic t_recover;
        logic p, pr; logic [7:0] told, t;
        step(1, 4'hA, 0, 8'h00, 0, 0, "R8", pr, told);
        step(1, 4'h1, 0, 8'h00, 0, 0, "R8", p, t);
        step(1, 4'h2, 0, 8'h00, 0, 0, "R8", p, t);
        step(0, 4'h0, 1, told, ~pr, 1, "R8", p, t);
        step(0, 4'h0, 0, 8'h00, 0, 0, "R8", p, t);
        check("R8", {4'd0, t[3:0]}, {4'd0, told[2:0], ~pr});
    endtask

    task automatic t_nomiss;
        logic p; logic [7:0] t; logic [HW-1:0] g;
        g = m_ghr;
        step(0, 4'h0, 1, 8'h5A, 1, 0, "R11", p, t);
        step(0, 4'h0, 0, 8'h00, 0, 0, "R11", p, t);
        check("R11", {4'd0, t[3:0]}, {4'd0, g});
    endtask

    task automatic t_priority;
        logic p; logic [7:0] t;
        step(1, 4'h3, 1, 8'h2B, 0, 1, "R9", p, t);
        step(0, 4'h0, 0, 8'h00, 0, 0, "R9", p, t);
        check("R9", {4'd0, t[3:0]}, 8'h06);  // 1011 -> 0110
    endtask

    task automatic t_same_entry;
        logic p; logic [7:0] t; int j;
        j = -1;
        for (int k = 0; k < 16; k++) if (j < 0 && m_pht[k] == 2'b01) j = k;
        if (j < 0) begin
            train(4'hE, 1, "R10");
            for (int k = 0; k < 3; k++) train(4'hE, 0, "R10");
            train(4'hE, 1, "R10");
            j = 14;
        end
        step(0, 4'(j) ^ m_ghr, 1, {4'(j), 4'h0}, 1, 0, "R10", p, t);
        check("R10", {7'd0, p}, 8'd0);
        peek(4'(j), "R10", p);
        check("R10", {7'd0, p}, 8'd1);
    endtask

    initial begin
        for (int k = 0; k < (1 << HW); k++) m_pht[k] = 2'b01;
        m_ghr = '0;
        rst = 1; fetch_valid = 0; fetch_pc_idx = '0;
        res_valid = 0; res_tag = '0; res_taken = 0; res_mispredict = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset;
        t_saturate;
        t_shift;
        t_stall;
        t_tag_train;
        t_recover;
        t_nomiss;
        t_priority;
        t_same_entry;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule